// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, per received frame, whether the frame goes on to the application. An upstream parser supplies the 48-bit destination and source addresses with a one-cycle valid strobe. The block compares them against a small bank of perfect-match address entries and a 64-bit hash table, and applies the configured filtering modes.

It returns a forward/drop decision together with two status bits, DA-fail and SA-fail, meant for the receive status word. All results are registered and appear on the cycle after the strobe. They hold their value until the next strobe.

The configuration inputs select the filtering modes. Promiscuous mode and receive-all mode both forward every frame, but they differ in what they report: receive-all still reports the true filter outcome. Broadcast rejection overrides everything else, while the hash and perfect comparisons can be combined or inverted.

Top module: `rxf_addr_filter`

## Requirements
- R1: `valid_o` is `valid_i` delayed by one clock. `forward_o`, `da_fail_o` and `sa_fail_o` are updated only on the clock edge that samples `valid_i` high, and otherwise hold their value.
- R2: With `promisc_i` set, the frame is forwarded and both fail bits are 0. The only exception is a broadcast frame dropped under R4.
- R3: With `rx_all_i` set, the frame is forwarded. The fail bits still report the real DA and SA results. The R4 exception also applies here.
- R4: A broadcast DA (all 48 bits 1) passes the DA check. With `bcast_reject_i` set, a broadcast frame is never forwarded, and `da_fail_o` is 1 unless `promisc_i` is set. This holds even with promiscuous or receive-all mode on.
- R5: The first byte on the wire is `da_i[47:40]`, and the group bit is `da_i[40]`. A non-broadcast DA with the group bit set is multicast. With `mcast_all_i` set, multicast frames pass the DA check whatever the other DA settings are.
- R6: When the frame's class (multicast or unicast) has its hash bit set (`hash_mc_i` or `hash_uc_i`), the DA is checked against the hash table. The CRC-32 is computed reflected (polynomial 0xEDB88320, initial value all ones) over the 6 DA bytes, first byte first and LSB first within each byte, and then complemented. The hash index is the bit-reversed result's upper 6 bits, so index bit 5 is CRC bit 0. The DA hits when `hash_tbl_i[index]` is 1.
- R7: A class without hash filtering hits when the DA equals all 48 bits of some entry whose enable bit is set and whose SA flag is 0.
- R8: With `hash_or_perf_i` set, a hash-filtered class also hits on a perfect DA match. With it clear, only the hash result counts.
- R9: With `da_inv_i` set, the DA check result (hash or perfect) is inverted for both unicast and multicast frames.
- R10: The SA hits when it equals all 48 bits, including bit 40, of some enabled entry whose SA flag is 1. The SA check passes on a hit, or on a miss when `sa_inv_i` is set.
- R11: When neither R2 nor R3 applies, a frame is forwarded if the DA check passes and, with `sa_filt_en_i` set, the SA check also passes. With `sa_filt_en_i` clear, an SA failure only raises `sa_fail_o`.
- R12: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Address pair valid strobe |
| da_i | input | 48 | Destination address, first byte in [47:40] |
| sa_i | input | 48 | Source address |
| promisc_i | input | 1 | Promiscuous mode |
| rx_all_i | input | 1 | Receive-all mode |
| bcast_reject_i | input | 1 | Drop broadcast frames |
| mcast_all_i | input | 1 | Pass all multicast |
| hash_mc_i | input | 1 | Hash filtering for multicast |
| hash_uc_i | input | 1 | Hash filtering for unicast |
| hash_or_perf_i | input | 1 | Hash classes also accept perfect matches |
| da_inv_i | input | 1 | Inverse DA filtering |
| sa_inv_i | input | 1 | Inverse SA filtering |
| sa_filt_en_i | input | 1 | SA failure drops the frame |
| hash_tbl_i | input | 64 | Hash table |
| perf_addr_i | input | 192 | Perfect entries, entry k in [48k+47:48k] |
| perf_en_i | input | 4 | Entry enable |
| perf_is_sa_i | input | 4 | Entry compares SA (1) or DA (0) |
| valid_o | output | 1 | Result valid |
| forward_o | output | 1 | Forward decision |
| da_fail_o | output | 1 | DA filter failed |
| sa_fail_o | output | 1 | SA filter failed |

## Verification
Every result is due exactly one clock after the edge that samples `valid_i`. The three result bits then stay frozen through idle cycles. The bench's reference model captures the expected values at the same posedge that the design samples. It compares all four outputs on the following falling edge, so each strobe is checked once when its result appears, and it is checked again on every idle cycle for holding.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned MAC_W = 48;
  localparam int unsigned HASH_W = 64;
  localparam int unsigned HIDX_W = $clog2(HASH_W);
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // reflected CRC-32 over DA bytes, first byte = a[47:40], LSB first
  function automatic logic [HIDX_W-1:0] hash_index(input logic [MAC_W-1:0] a);
    logic [31:0] c;
    logic fb;
    logic [HIDX_W-1:0] r;
    c = '1;
    for (int b = 0; b < MAC_W/8; b++) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ a[MAC_W-8-8*b+i];
        c  = c >> 1;
        if (fb) c = c ^ CRC_POLY_REFL;
      end
    end
    c = ~c;
    for (int j = 0; j < HIDX_W; j++) r[HIDX_W-1-j] = c[j];
    return r;
  endfunction
endpackage

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup
  import rxf_pkg::*;
#(
  parameter int unsigned TBL_W = HASH_W
) (
  input  logic [MAC_W-1:0] da_i,
  input  logic [TBL_W-1:0] tbl_i,
  output logic             hit_o
);
  localparam int unsigned IW = $clog2(TBL_W);
  logic [HIDX_W-1:0] idx_full;
  logic [IW-1:0]     idx;

  assign idx_full = hash_index(da_i);
  assign idx      = idx_full[HIDX_W-1 -: IW];
  assign hit_o    = tbl_i[idx];
endmodule

// File: rtl/rxf_perfect_match.sv
module rxf_perfect_match
  import rxf_pkg::*;
#(
  parameter int unsigned N_ENT = 4
) (
  input  logic [MAC_W-1:0]       da_i,
  input  logic [MAC_W-1:0]       sa_i,
  input  logic [N_ENT*MAC_W-1:0] addr_i,
  input  logic [N_ENT-1:0]       en_i,
  input  logic [N_ENT-1:0]       is_sa_i,
  output logic                   da_hit_o,
  output logic                   sa_hit_o
);
  logic [N_ENT-1:0] da_m, sa_m;

  for (genvar k = 0; k < N_ENT; k++) begin : g_ent
    logic [MAC_W-1:0] ent;
    assign ent     = addr_i[k*MAC_W +: MAC_W];
    assign da_m[k] = en_i[k] & ~is_sa_i[k] & (ent == da_i);
    assign sa_m[k] = en_i[k] &  is_sa_i[k] & (ent == sa_i);
  end

  assign da_hit_o = |da_m;
  assign sa_hit_o = |sa_m;
endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned N_ENT = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [MAC_W-1:0]       da_i,
  input  logic [MAC_W-1:0]       sa_i,
  input  logic                   promisc_i,
  input  logic                   rx_all_i,
  input  logic                   bcast_reject_i,
  input  logic                   mcast_all_i,
  input  logic                   hash_mc_i,
  input  logic                   hash_uc_i,
  input  logic                   hash_or_perf_i,
  input  logic                   da_inv_i,
  input  logic                   sa_inv_i,
  input  logic                   sa_filt_en_i,
  input  logic [HASH_W-1:0]      hash_tbl_i,
  input  logic [N_ENT*MAC_W-1:0] perf_addr_i,
  input  logic [N_ENT-1:0]       perf_en_i,
  input  logic [N_ENT-1:0]       perf_is_sa_i,
  output logic                   valid_o,
  output logic                   forward_o,
  output logic                   da_fail_o,
  output logic                   sa_fail_o
);
  logic hash_hit, perf_da_hit, perf_sa_hit;
  logic is_bc, is_mc, hash_cls, cls_hit, da_ok, sa_ok, bc_drop;
  logic fwd_d, da_fail_d, sa_fail_d;

  rxf_hash_lookup #(.TBL_W(HASH_W)) u_hash (
    .da_i  (da_i),
    .tbl_i (hash_tbl_i),
    .hit_o (hash_hit)
  );

  rxf_perfect_match #(.N_ENT(N_ENT)) u_perf (
    .da_i     (da_i),
    .sa_i     (sa_i),
    .addr_i   (perf_addr_i),
    .en_i     (perf_en_i),
    .is_sa_i  (perf_is_sa_i),
    .da_hit_o (perf_da_hit),
    .sa_hit_o (perf_sa_hit)
  );

  always_comb begin
    is_bc    = &da_i;
    is_mc    = da_i[MAC_W-8] & ~is_bc;
    hash_cls = is_mc ? hash_mc_i : hash_uc_i;
    cls_hit  = hash_cls ? (hash_hit | (hash_or_perf_i & perf_da_hit)) : perf_da_hit;
    if (is_bc)                  da_ok = 1'b1;
    else if (is_mc && mcast_all_i) da_ok = 1'b1;
    else                        da_ok = cls_hit ^ da_inv_i;
    sa_ok   = perf_sa_hit ^ sa_inv_i;
    bc_drop = is_bc & bcast_reject_i;
    if (bc_drop)                     fwd_d = 1'b0;
    else if (promisc_i || rx_all_i)  fwd_d = 1'b1;
    else                             fwd_d = da_ok & (sa_ok | ~sa_filt_en_i);
    da_fail_d = ~promisc_i & (bc_drop | ~da_ok);
    sa_fail_d = ~promisc_i & ~sa_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      forward_o <= 1'b0;
      da_fail_o <= 1'b0;
      sa_fail_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        forward_o <= fwd_d;
        da_fail_o <= da_fail_d;
        sa_fail_o <= sa_fail_d;
      end
    end
  end
endmodule

// File: rtl/rxf_addr_filter_chk.sv
module rxf_addr_filter_chk
  import rxf_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [MAC_W-1:0] da_i,
  input logic             promisc_i,
  input logic             rx_all_i,
  input logic             bcast_reject_i,
  input logic             sa_filt_en_i,
  input logic             valid_o,
  input logic             forward_o,
  input logic             da_fail_o,
  input logic             sa_fail_o
);
  logic bc_in;
  assign bc_in = &da_i;

  p_valid_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_lat_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(forward_o) && $stable(da_fail_o) && $stable(sa_fail_o)));
  p_promisc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && promisc_i) |=> (!da_fail_o && !sa_fail_o));
  p_rx_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (rx_all_i || promisc_i) && !(bc_in && bcast_reject_i)) |=> forward_o);
  p_bcast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bc_in && bcast_reject_i) |=> !forward_o);
  p_sa_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sa_filt_en_i && !promisc_i && !rx_all_i) |=> !(forward_o && sa_fail_o));
  p_reset_r12: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !forward_o && !da_fail_o && !sa_fail_o));
endmodule

bind rxf_addr_filter rxf_addr_filter_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .da_i           (da_i),
  .promisc_i      (promisc_i),
  .rx_all_i       (rx_all_i),
  .bcast_reject_i (bcast_reject_i),
  .sa_filt_en_i   (sa_filt_en_i),
  .valid_o        (valid_o),
  .forward_o      (forward_o),
  .da_fail_o      (da_fail_o),
  .sa_fail_o      (sa_fail_o)
);

// File: tb/tb_rxf_addr_filter.sv
module tb_rxf_addr_filter;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic valid = 0;
  logic [47:0] da = 0, sa = 0;
  logic promisc = 0, rx_all = 0, bcrej = 0, mcall = 0, hmc = 0, huc = 0, hop = 0;
  logic dainv = 0, sainv = 0, safen = 0;
  logic [63:0] tbl = 0;
  logic [47:0] pa [4];
  logic [3:0] pe = 0, ps = 0;
  logic [191:0] pa_flat;
  logic v_o, f_o, df_o, sf_o;

  always_comb for (int k = 0; k < 4; k++) pa_flat[k*48 +: 48] = pa[k];

  rxf_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .da_i(da), .sa_i(sa),
    .promisc_i(promisc), .rx_all_i(rx_all), .bcast_reject_i(bcrej), .mcast_all_i(mcall),
    .hash_mc_i(hmc), .hash_uc_i(huc), .hash_or_perf_i(hop), .da_inv_i(dainv),
    .sa_inv_i(sainv), .sa_filt_en_i(safen), .hash_tbl_i(tbl), .perf_addr_i(pa_flat),
    .perf_en_i(pe), .perf_is_sa_i(ps), .valid_o(v_o), .forward_o(f_o),
    .da_fail_o(df_o), .sa_fail_o(sf_o));

  int n_cmp = 0, n_err = 0;
  string tag = "R12";
  logic done = 0;

  function automatic [5:0] ref_idx(input [47:0] a);
    reg [31:0] c; reg [7:0] by; reg [5:0] r;
    c = 32'hFFFFFFFF;
    for (int n = 0; n < 6; n++) begin
      by = a[47-8*n -: 8];
      for (int k = 0; k < 8; k++) begin
        if ((c[0] ^ by[0]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
        by = by >> 1;
      end
    end
    c = ~c;
    for (int j = 0; j < 6; j++) r[5-j] = c[j];
    return r;
  endfunction

  // returns {forward, da_fail, sa_fail}
  function automatic [2:0] ref_model();
    bit bc, mc, dhit, shit, hh, dpass, spass, fw, dfl, sfl;
    bc = (da == 48'hFFFF_FFFF_FFFF);
    mc = da[40] && !bc;
    dhit = 0; shit = 0;
    for (int k = 0; k < 4; k++) begin
      if (pe[k] && !ps[k] && pa[k] == da) dhit = 1;
      if (pe[k] &&  ps[k] && pa[k] == sa) shit = 1;
    end
    hh = tbl[ref_idx(da)];
    if (bc) dpass = 1;
    else if (mc && mcall) dpass = 1;
    else begin
      if ((mc && hmc) || (!mc && huc)) dpass = hh || (hop && dhit);
      else dpass = dhit;
      if (dainv) dpass = !dpass;
    end
    spass = sainv ? !shit : shit;
    if (bc && bcrej) fw = 0;
    else if (promisc || rx_all) fw = 1;
    else fw = dpass && (spass || !safen);
    dfl = promisc ? 0 : ((bc && bcrej) || !dpass);
    sfl = promisc ? 0 : !spass;
    return {fw, dfl, sfl};
  endfunction

  logic ev = 0, ef = 0, ed = 0, es = 0;
  string etag = "R12";
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev <= 0; ef <= 0; ed <= 0; es <= 0;
    end else begin
      ev <= valid;
      if (valid) begin
        {ef, ed, es} <= ref_model();
        etag <= tag;
      end
    end
  end

  task automatic chk1(input string req, input string nm, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk1(rst_n ? "R1" : "R12", "valid_o", v_o, ev);
    chk1(rst_n ? etag : "R12", "forward_o", f_o, ef);
    chk1(rst_n ? etag : "R12", "da_fail_o", df_o, ed);
    chk1(rst_n ? etag : "R12", "sa_fail_o", sf_o, es);
  end

  task automatic send(input [47:0] d, input [47:0] s);
    @(negedge clk); valid <= 1; da <= d; sa <= s;
    @(negedge clk); valid <= 0;
  endtask

  task automatic clear_cfg();
    @(negedge clk);
    promisc <= 0; rx_all <= 0; bcrej <= 0; mcall <= 0; hmc <= 0; huc <= 0; hop <= 0;
    dainv <= 0; sainv <= 0; safen <= 0; tbl <= 0;
  endtask

  task automatic finish_sim();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_sim();
  end

  localparam logic [47:0] UA = 48'h0200_1122_3344, UB = 48'h0200_5566_7788;
  localparam logic [47:0] MA = 48'h0100_5E00_0001, SAA = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] SAG = 48'h0B0B_0C0D_0E0F, BC = 48'hFFFF_FFFF_FFFF;
  logic [47:0] hx, hy;

  initial begin
    pa[0] = UA; pa[1] = MA; pa[2] = SAA; pa[3] = SAG;
    pe = 4'b1111; ps = 4'b1100;
    repeat (3) @(negedge clk);
    tag = "R12";
    @(negedge clk); rst_n = 1;
    // R7 perfect DA
    tag = "R7";
    send(UA, SAA); send(UB, SAA); send(MA, SAA); send(48'h0100_5E00_0002, SAA);
    pe[0] = 0; send(UA, SAA); pe[0] = 1;
    // R6 hash
    hx = 48'h0200_AABB_CC01; hy = hx;
    while (ref_idx(hy) == ref_idx(hx)) hy = hy + 1;
    clear_cfg(); tag = "R6";
    huc <= 1; tbl <= 64'd1 << ref_idx(hx);
    send(hx, SAA); send(hy, SAA); send(UA, SAA);
    hmc <= 1; tbl <= 64'd1 << ref_idx(MA); send(MA, SAA); send(48'h0100_5E00_0077, SAA);
    // R8 hash or perfect
    tag = "R8"; tbl <= 64'd1 << ref_idx(hx); hop <= 1;
    send(UA, SAA); send(hx, SAA); send(hy, SAA); hop <= 0; send(UA, SAA);
    // R5 multicast
    clear_cfg(); tag = "R5"; hmc <= 1; mcall <= 1;
    send(48'h0100_5E12_3456, SAA); send(48'h0300_0000_0001, SAA); dainv <= 1;
    send(48'h0100_5E12_3456, SAA); mcall <= 0; dainv <= 0;
    send(48'h0100_5E12_3456, SAA); send(UB, SAA);
    // R9 inverse DA
    clear_cfg(); tag = "R9"; dainv <= 1;
    send(UA, SAA); send(UB, SAA); send(MA, SAA); huc <= 1; tbl <= 64'd1 << ref_idx(hx);
    send(hx, SAA); send(hy, SAA);
    // R10 SA match
    clear_cfg(); tag = "R10";
    send(UA, SAA); send(UA, SAG); send(UA, 48'h0A0B_0C0D_0E0E); send(UA, SAA ^ 48'h0100_0000_0000);
    sainv <= 1; send(UA, SAA); send(UA, 48'h1234_5678_9ABC);
    // R11 SA filter enable
    clear_cfg(); tag = "R11"; safen <= 1;
    send(UA, SAA); send(UA, 48'h1234_5678_9ABC); send(UB, SAA);
    safen <= 0; send(UA, 48'h1234_5678_9ABC);
    // R2 promiscuous
    clear_cfg(); tag = "R2"; promisc <= 1; safen <= 1;
    send(UB, 48'h1234_5678_9ABC); send(MA, SAA); send(BC, SAA);
    // R3 receive all
    clear_cfg(); tag = "R3"; rx_all <= 1; safen <= 1;
    send(UB, 48'h1234_5678_9ABC); send(UA, SAA); send(UA, 48'h1234_5678_9ABC);
    // R4 broadcast reject
    clear_cfg(); tag = "R4";
    send(BC, SAA); bcrej <= 1; send(BC, SAA); promisc <= 1; send(BC, SAA);
    promisc <= 0; rx_all <= 1; send(BC, SAA); mcall <= 1; send(BC, SAA); send(UA, SAA);
    // R1 random traffic with idle gaps
    tag = "R1";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      valid <= ($urandom_range(0, 2) != 0);
      case ($urandom_range(0, 5))
        0: da <= UA; 1: da <= MA; 2: da <= BC; 3: da <= hx;
        default: da <= {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      endcase
      sa <= ($urandom_range(0, 1) != 0) ? SAA : {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      {promisc, rx_all, bcrej, mcall, hmc, huc, hop, dainv, sainv, safen} <= 10'($urandom) & 10'($urandom);
      tbl <= {$urandom, $urandom};
      pe <= 4'($urandom) | 4'b0101;
    end
    @(negedge clk); valid <= 0;
    repeat (4) @(negedge clk);
    finish_sim();
  end
endmodule